// File: doc/BRIEF.md
# Serial Converter Power-Mode Sequencer

This block is the digital power-management controller of a serially controlled sampling converter. It runs on a fast system clock. It oversamples the active-low chip select, the serial clock and the serial data input through a synchronizer. From each frame it shifts in a 15-bit control word, and that word selects one of four power modes. At a fixed serial-clock edge of the frame the block moves the converter into the selected low-power state. It holds the converter there while chip select stays low. When chip select goes high again, it starts a timed power-up.

The outputs tell the analog side whether to power down the core, whether to power down the on-chip reference, and whether the track/hold stage tracks or holds. A ready flag rises once the power-up time for the mode being left has elapsed. The two power-up times are counted in system clock cycles and set by parameters. A frame that begins before the converter is ready is marked with an invalid-conversion flag. Such a frame does not disturb the power-up count. The analog conversion and the result path are outside this block.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset: ready=1, corePowerDown=0, refPowerDown=0, trackMode=1, convInvalid=0, pmMode=2'b00, refEnable=1.
- R2: A frame starts when csN falls. The first 15 rising sclk edges shift din in, MSB first, into word bits 14 down to 0. On the 15th edge the word is loaded, but only if bit 14 (write) is 1. Bits 9:8 give pmMode and bit 1 gives refEnable. A word with bit 14 = 0 leaves both fields unchanged.
- R3: With pmMode 2'b10 (auto-shutdown) in effect at the 15th edge, the block enters shutdown. The outputs are then corePowerDown=1, refPowerDown=1, trackMode=0 and ready=0, and they hold for as long as csN stays low.
- R4: With pmMode 2'b01 (auto-standby) in effect at the 15th edge, the block enters standby. The outputs are then corePowerDown=1, trackMode=0 and ready=0. refPowerDown=0 as long as refEnable=1.
- R5: A csN rising edge in a low-power state starts power-up. trackMode returns to 1 and corePowerDown returns to 0 at once, while ready stays 0.
- R6: ready rises SHUTDOWN_CYCLES system cycles after power-up starts when leaving shutdown, and STANDBY_CYCLES cycles after it starts when leaving standby. Both counts are measured after input synchronization.
- R7: At each frame start, convInvalid is set to 1 if ready is 0 and cleared to 0 if ready is 1. A frame that starts during power-up does not restart the power-up count.
- R8: After power-up, a frame with no write and an auto mode still loaded puts the block back into the same low-power state at its 15th edge.
- R9: pmMode 2'b00 causes no power-down, and ready stays 1 across frames.
- R10: pmMode 2'b11 is full shutdown (corePowerDown=1, refPowerDown=1, trackMode=0, ready=0). csN edges and frames without a write do not end it. A write with pmMode 2'b00 ends it with a power-up of SHUTDOWN_CYCLES.
- R11: pmMode and refEnable keep their values through shutdown and standby.
- R12: refPowerDown=1 whenever refEnable=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous and slower than clk |
| din | input | 1 | Serial data in, sampled on rising sclk |
| corePowerDown | output | 1 | Powers down converter core circuitry |
| refPowerDown | output | 1 | Powers down the on-chip reference |
| trackMode | output | 1 | 1 = track/hold tracks, 0 = holds |
| ready | output | 1 | Converter fully powered, conversions valid |
| convInvalid | output | 1 | Current frame began before ready |
| pmMode | output | 2 | Loaded power-mode field |
| refEnable | output | 1 | Loaded reference-enable field |

## Verification
The bench builds the block with SHUTDOWN_CYCLES=60, STANDBY_CYCLES=12 and SYNC_STAGES=2. With these values both power-up windows fit into a few dozen cycles, so each ready edge can be bracketed just before and just after its expected cycle. The two delays differ widely, so a wrong choice between them shows up as a ready flag that is late or early. The short shutdown window also lets the bench start a frame in the middle of power-up and see whether the timer is restarted.

// File: rtl/adc_pwr_seq_pkg.sv
package adc_pwr_seq_pkg;

  // Control word layout (MSB shifted first)
  localparam int WORD_BITS = 15;
  localparam int WRITE_POS = 14;
  localparam int PM_HI     = 9;
  localparam int PM_LO     = 8;
  localparam int REF_POS   = 1;

  typedef enum logic [1:0] {
    PM_NORMAL   = 2'b00,
    PM_STANDBY  = 2'b01,
    PM_SHUTDOWN = 2'b10,
    PM_FULLOFF  = 2'b11
  } pmMode_e;

  typedef enum logic [1:0] {
    ST_ACTIVE,
    ST_LOWPWR,
    ST_POWERUP,
    ST_FULLOFF
  } pwrState_e;

  // datapath -> control
  typedef struct packed {
    logic       frameStart;
    logic       csRise;
    logic       wordDone;
    logic       wordWrite;
    logic [1:0] wordPm;
    logic       timerDone;
  } dpStatus_t;

  // control -> datapath
  typedef struct packed {
    logic loadTimer;
    logic longDelay;
  } ctlStrobe_t;

endpackage

// File: rtl/adc_pwr_seq_sync.sv
module adc_pwr_seq_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= RESET_VAL;
          else       stage[0] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= RESET_VAL;
          else       stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/adc_pwr_seq_datapath.sv
module adc_pwr_seq_datapath
  import adc_pwr_seq_pkg::*;
#(
  parameter int SHUTDOWN_CYCLES = 100000,
  parameter int STANDBY_CYCLES = 140,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       din,
  input  ctlStrobe_t cmd,
  output dpStatus_t  stat,
  output logic [1:0] pmReg,
  output logic       refEnReg
);

  localparam int CNT_W  = $clog2(WORD_BITS + 2);
  localparam int MAX_D  = (SHUTDOWN_CYCLES > STANDBY_CYCLES) ? SHUTDOWN_CYCLES : STANDBY_CYCLES;
  localparam int TIMER_W = $clog2(MAX_D + 1);
  localparam int SHIFT_W = WORD_BITS - 1;

  logic [2:0] syncOut;
  logic csS, sclkS, dinS;
  logic csPrev, sclkPrev;
  logic frameStart, csRise, sclkRise, wordDone;
  logic [CNT_W-1:0] bitCnt;
  logic [SHIFT_W-1:0] shiftReg;
  logic [TIMER_W-1:0] timer;
  logic wordWrite, wordRef;
  logic [1:0] wordPm;

  adc_pwr_seq_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(3'b100)
  ) i_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({csN, sclk, din}),
    .syncOut(syncOut)
  );

  assign {csS, sclkS, dinS} = syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign frameStart = csPrev & ~csS;
  assign csRise     = ~csPrev & csS;
  assign sclkRise   = ~sclkPrev & sclkS & ~csS;
  assign wordDone   = sclkRise && (bitCnt == CNT_W'(WORD_BITS - 1));

  // Word bit k sits in shiftReg[k-1] on the last edge; bit 0 is dinS.
  assign wordWrite = shiftReg[WRITE_POS-1];
  assign wordPm    = {shiftReg[PM_HI-1], shiftReg[PM_LO-1]};
  assign wordRef   = shiftReg[REF_POS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (frameStart) begin
      bitCnt <= '0;
    end else if (sclkRise && bitCnt != CNT_W'(WORD_BITS + 1)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (sclkRise && bitCnt < CNT_W'(WORD_BITS - 1)) begin
      shiftReg <= {shiftReg[SHIFT_W-2:0], dinS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pmReg    <= PM_NORMAL;
      refEnReg <= 1'b1;
    end else if (wordDone && wordWrite) begin
      pmReg    <= wordPm;
      refEnReg <= wordRef;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (cmd.loadTimer) begin
      timer <= cmd.longDelay ? TIMER_W'(SHUTDOWN_CYCLES - 1) : TIMER_W'(STANDBY_CYCLES - 1);
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  always_comb begin
    stat.frameStart = frameStart;
    stat.csRise     = csRise;
    stat.wordDone   = wordDone;
    stat.wordWrite  = wordWrite;
    stat.wordPm     = wordPm;
    stat.timerDone  = (timer == '0);
  end

endmodule

// File: rtl/adc_pwr_seq_ctrl.sv
module adc_pwr_seq_ctrl
  import adc_pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  stat,
  input  logic [1:0] pmReg,
  input  logic       refEnReg,
  output ctlStrobe_t cmd,
  output logic       corePowerDown,
  output logic       refPowerDown,
  output logic       trackMode,
  output logic       ready,
  output logic       convInvalid
);

  pwrState_e state, nextState;
  logic lowShut, nextLowShut;
  pmMode_e newPm;

  assign newPm = pmMode_e'(stat.wordWrite ? stat.wordPm : pmReg);

  always_comb begin
    nextState     = state;
    nextLowShut   = lowShut;
    cmd.loadTimer = 1'b0;
    cmd.longDelay = 1'b0;
    case (state)
      ST_ACTIVE: begin
        if (stat.wordDone) begin
          case (newPm)
            PM_SHUTDOWN: begin nextState = ST_LOWPWR; nextLowShut = 1'b1; end
            PM_STANDBY:  begin nextState = ST_LOWPWR; nextLowShut = 1'b0; end
            PM_FULLOFF:  nextState = ST_FULLOFF;
            default:     nextState = ST_ACTIVE;
          endcase
        end
      end
      ST_LOWPWR: begin
        if (stat.csRise) begin
          nextState     = ST_POWERUP;
          cmd.loadTimer = 1'b1;
          cmd.longDelay = lowShut;
        end
      end
      ST_POWERUP: begin
        if (stat.timerDone) nextState = ST_ACTIVE;
      end
      ST_FULLOFF: begin
        if (stat.wordDone && stat.wordWrite) begin
          case (newPm)
            PM_NORMAL: begin
              nextState     = ST_POWERUP;
              cmd.loadTimer = 1'b1;
              cmd.longDelay = 1'b1;
            end
            PM_SHUTDOWN: begin nextState = ST_LOWPWR; nextLowShut = 1'b1; end
            PM_STANDBY:  begin nextState = ST_LOWPWR; nextLowShut = 1'b0; end
            default:     nextState = ST_FULLOFF;
          endcase
        end
      end
      default: nextState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ACTIVE;
      lowShut <= 1'b0;
    end else begin
      state   <= nextState;
      lowShut <= nextLowShut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) convInvalid <= 1'b0;
    else if (stat.frameStart) convInvalid <= (state != ST_ACTIVE);
  end

  assign ready         = (state == ST_ACTIVE);
  assign trackMode     = (state == ST_ACTIVE) || (state == ST_POWERUP);
  assign corePowerDown = (state == ST_LOWPWR) || (state == ST_FULLOFF);
  assign refPowerDown  = (state == ST_FULLOFF) || ((state == ST_LOWPWR) && lowShut) || !refEnReg;

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_seq_pkg::*;
#(
  parameter int SHUTDOWN_CYCLES = 100000,
  parameter int STANDBY_CYCLES = 140,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       din,
  output logic       corePowerDown,
  output logic       refPowerDown,
  output logic       trackMode,
  output logic       ready,
  output logic       convInvalid,
  output logic [1:0] pmMode,
  output logic       refEnable
);

  dpStatus_t  stat;
  ctlStrobe_t cmd;

  adc_pwr_seq_datapath #(
    .SHUTDOWN_CYCLES(SHUTDOWN_CYCLES),
    .STANDBY_CYCLES(STANDBY_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk(clk),
    .rstN(rstN),
    .csN(csN),
    .sclk(sclk),
    .din(din),
    .cmd(cmd),
    .stat(stat),
    .pmReg(pmMode),
    .refEnReg(refEnable)
  );

  adc_pwr_seq_ctrl i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .stat(stat),
    .pmReg(pmMode),
    .refEnReg(refEnable),
    .cmd(cmd),
    .corePowerDown(corePowerDown),
    .refPowerDown(refPowerDown),
    .trackMode(trackMode),
    .ready(ready),
    .convInvalid(convInvalid)
  );

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       corePowerDown,
  input logic       refPowerDown,
  input logic       trackMode,
  input logic       ready,
  input logic       convInvalid,
  input logic [1:0] pmMode,
  input logic       refEnable
);

  // R3
  core_down_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    corePowerDown |-> (!ready && !trackMode));

  // R5
  ready_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (trackMode && !corePowerDown));

  // R6
  ready_from_powerup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(trackMode) && !$past(corePowerDown)));

  // R7
  invalid_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convInvalid) |-> !$past(ready));

  // R11
  mode_retained_chk: assert property (@(posedge clk) disable iff (!rstN)
    (corePowerDown && $past(corePowerDown) && $past(pmMode) != 2'b11) |-> ($stable(pmMode) && $stable(refEnable)));

  // R12
  ref_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refEnable |-> refPowerDown);

endmodule

bind adc_pwr_seq adc_pwr_seq_chk i_chk (.*);

// File: tb/test_adc_pwr_seq.sv
`timescale 1ns/1ps
module test_adc_pwr_seq;

  localparam int SD = 60;
  localparam int SB = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic corePowerDown, refPowerDown, trackMode, ready, convInvalid, refEnable;
  logic [1:0] pmMode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  adc_pwr_seq #(
    .SHUTDOWN_CYCLES(SD),
    .STANDBY_CYCLES(SB),
    .SYNC_STAGES(2)
  ) i_adc_pwr_seq (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .corePowerDown(corePowerDown), .refPowerDown(refPowerDown),
    .trackMode(trackMode), .ready(ready), .convInvalid(convInvalid),
    .pmMode(pmMode), .refEnable(refEnable)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] mkWord(input logic wr, input logic [1:0] pm, input logic rf);
    logic [14:0] w = '0;
    w[14] = wr;
    w[9:8] = pm;
    w[1] = rf;
    return w;
  endfunction

  // 16 sclk edges, word MSB first; csN left low unless raise
  task automatic frame(input logic [14:0] w, input bit raise);
    csN = 1'b0;
    tick(4);
    for (int i = 0; i < 16; i++) begin
      din = (i < 15) ? w[14 - i] : 1'b0;
      tick(3);
      sclk = 1'b1;
      tick(3);
      sclk = 1'b0;
    end
    tick(6);
    if (raise) begin
      csN = 1'b1;
      tick(6);
    end
  endtask

  task automatic t_reset;
    chk("R1 ready", ready, 1);
    chk("R1 core", corePowerDown, 0);
    chk("R1 ref", refPowerDown, 0);
    chk("R1 track", trackMode, 1);
    chk("R1 invalid", convInvalid, 0);
    chk("R1 pm", pmMode, 0);
    chk("R1 refEn", refEnable, 1);
  endtask

  task automatic t_normal;
    frame(mkWord(1, 2'b00, 1), 1);
    chk("R9 ready after normal", ready, 1);
    chk("R9 core", corePowerDown, 0);
    frame(mkWord(0, 2'b10, 0), 1);
    chk("R2 no-write pm", pmMode, 0);
    chk("R2 no-write refEn", refEnable, 1);
    chk("R9 ready no-write", ready, 1);
  endtask

  task automatic t_shutdown;
    frame(mkWord(1, 2'b10, 1), 0);
    chk("R2 pm loaded", pmMode, 2);
    chk("R3 core", corePowerDown, 1);
    chk("R3 ref", refPowerDown, 1);
    chk("R3 track", trackMode, 0);
    chk("R3 ready", ready, 0);
    tick(20);
    chk("R3 held core", corePowerDown, 1);
    chk("R11 pm held", pmMode, 2);
    chk("R11 refEn held", refEnable, 1);
    csN = 1'b1;
    tick(6);
    chk("R5 track", trackMode, 1);
    chk("R5 core up", corePowerDown, 0);
    chk("R5 ready low", ready, 0);
    tick(SD - 12);
    chk("R6 shutdown early", ready, 0);
    tick(14);
    chk("R6 shutdown done", ready, 1);
  endtask

  task automatic t_reenter;
    frame(mkWord(0, 2'b00, 0), 0);
    chk("R8 back to shutdown", corePowerDown, 1);
    chk("R8 ref", refPowerDown, 1);
    chk("R7 valid frame", convInvalid, 0);
    csN = 1'b1;
    tick(SD + 8);
    chk("R8 ready again", ready, 1);
  endtask

  task automatic t_standby;
    frame(mkWord(1, 2'b01, 1), 0);
    chk("R4 core", corePowerDown, 1);
    chk("R4 ref on", refPowerDown, 0);
    chk("R4 track", trackMode, 0);
    chk("R4 ready", ready, 0);
    chk("R11 pm standby", pmMode, 1);
    csN = 1'b1;
    tick(6);
    chk("R5 standby track", trackMode, 1);
    chk("R6 standby early", ready, 0);
    tick(14);
    chk("R6 standby done", ready, 1);
  endtask

  task automatic t_invalid;
    frame(mkWord(1, 2'b10, 1), 0);
    csN = 1'b1;
    tick(6);
    csN = 1'b0;
    tick(6);
    chk("R7 invalid set", convInvalid, 1);
    tick(SD - 18);
    chk("R7 count early", ready, 0);
    tick(14);
    chk("R7 count not restarted", ready, 1);
    csN = 1'b1;
    tick(6);
    frame(mkWord(1, 2'b00, 1), 1);
    chk("R7 invalid cleared", convInvalid, 0);
    chk("R9 ready", ready, 1);
  endtask

  task automatic t_refoff;
    frame(mkWord(1, 2'b00, 0), 1);
    chk("R12 ref down", refPowerDown, 1);
    chk("R12 core up", corePowerDown, 0);
    chk("R2 refEn loaded", refEnable, 0);
    frame(mkWord(1, 2'b00, 1), 1);
    chk("R12 ref back", refPowerDown, 0);
  endtask

  task automatic t_fulloff;
    frame(mkWord(1, 2'b11, 1), 1);
    chk("R10 core", corePowerDown, 1);
    chk("R10 ref", refPowerDown, 1);
    chk("R10 track", trackMode, 0);
    chk("R10 ready", ready, 0);
    frame(mkWord(0, 2'b00, 1), 1);
    tick(SD + 8);
    chk("R10 stays off", corePowerDown, 1);
    chk("R11 pm fulloff", pmMode, 3);
    frame(mkWord(1, 2'b00, 1), 1);
    chk("R10 powering", ready, 0);
    chk("R10 core up", corePowerDown, 0);
    tick(SD);
    chk("R10 ready", ready, 1);
  endtask

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(2);
    t_reset;
    t_normal;
    t_shutdown;
    t_reenter;
    t_standby;
    t_invalid;
    t_refoff;
    t_fulloff;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule